// File: doc/BRIEF.md
# Access Violation Monitor

The monitor sits beside a memory permission checker and watches its deny strobe. While monitoring is enabled and no earlier fault is waiting, the first denied access has its attributes latched: a compressed word address, the direction (read or write), whether it was a data load/store or an instruction fetch, the privilege world and the byte-enable mask. A level interrupt is raised at the same moment and stays high until software pulses a clear bit.

Software reaches the monitor through a small register port with four word registers: a lock, a control register, and two read-only status registers. The fault address is stored as a word index relative to a region base, plus one, so that a field of zero always means that nothing was captured. Software restores the byte address as `(field << SHIFT) + REGION_BASE - 2**SHIFT`. Once the lock is set, the enable setting can no longer be changed until reset, while clearing a fault stays possible.

Top module: `acc_viol_mon`

## Requirements
- R1: After reset the interrupt is low and all four registers (index 0 lock, 1 control, 2 status A, 3 status B on `reg_idx_i`) read as zero.
- R2: A deny pulse seen at a clock edge while the enable is set, the clear bit is low and no fault is pending drives `irq_o` high from that edge on. Status A then holds: bit 0 pending, bit 1 load/store, bits 3:2 world, bits 7:4 byte enables, bits 27:8 address field. Status B bit 0 holds the write flag.
- R3: A deny pulse while the enable bit (control bit 0) is low captures nothing: the interrupt stays low and status reads zero.
- R4: While a fault is pending, further deny pulses change neither the interrupt nor any captured field.
- R5: While the clear bit (control bit 1) is set, from the second edge after it is written, the interrupt and all captured fields are zero and deny pulses are not captured; after the bit is released a new fault is captured normally.
- R6: The address field equals `((addr - REGION_BASE) >> SHIFT) + 1` truncated to 20 bits; with the defaults (base 0x4000_0000, shift 2) an access at the base reports 1 and one at base + 0x10 reports 5.
- R7: Writing a 1 in bit 0 of the lock register sets the lock, which reads back as 1; writing 0 never clears it before reset.
- R8: While locked, writes to the control register leave the enable bit unchanged but still update the clear bit.
- R9: Writes to the two status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deny_i | input | 1 | Denied-access strobe from the permission checker |
| acc_addr_i | input | AW | Byte address of the access |
| acc_wr_i | input | 1 | 1 for write, 0 for read |
| acc_ls_i | input | 1 | 1 for load/store, 0 for fetch |
| acc_world_i | input | 2 | Privilege world of the access |
| acc_be_i | input | 4 | Byte enables of the access |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the indexed register |
| irq_o | output | 1 | Level interrupt, high while a fault is pending |

## Verification
The hardest situations to reach are those where two controls interact: a deny arriving while the clear bit is held, and a control write arriving after the lock, where the enable must hold but the clear bit must still act. The stimulus first creates a pending fault, then holds the clear bit while pulsing deny, and only after releasing it captures a fault at the region base to show the field is 1, not 0. The lock sequence sets the lock with monitoring enabled, tries to disable monitoring, and proves through a fresh capture that the enable stayed on before clearing that capture through the locked control register.

// File: rtl/avm_pkg.sv
package avm_pkg;
  localparam int unsigned WORLD_W = 2;
  localparam int unsigned BE_W    = 4;
  localparam int unsigned FIELD_W = 20;

  typedef enum logic [1:0] {
    RIDX_LOCK = 2'd0,
    RIDX_CTRL = 2'd1,
    RIDX_STA  = 2'd2,
    RIDX_STB  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic               wr;
    logic               ls;
    logic [WORLD_W-1:0] world;
    logic [BE_W-1:0]    be;
    logic [FIELD_W-1:0] field;
  } fault_rec_t;
endpackage

// File: rtl/avm_addr_pack.sv
module avm_addr_pack #(
  parameter int unsigned AW          = 32,
  parameter int unsigned SHIFT       = 2,
  parameter logic [AW-1:0] REGION_BASE = 32'h4000_0000
) (
  input  logic [AW-1:0]                addr_i,
  output logic [avm_pkg::FIELD_W-1:0] field_o
);
  localparam int unsigned FW = avm_pkg::FIELD_W;

  logic [AW-1:0] rel, idx;

  // index + 1 keeps zero free as the "nothing captured" code
  always_comb begin
    rel     = addr_i - REGION_BASE;
    idx     = rel >> SHIFT;
    field_o = idx[FW-1:0] + FW'(1);
  end
endmodule

// File: rtl/avm_cfg.sv
module avm_cfg
  import avm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  reg_idx_e    idx_i,
  input  logic [31:0] wdata_i,
  output logic        lock_o,
  output logic        en_o,
  output logic        clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      en_o   <= 1'b0;
      clr_o  <= 1'b0;
    end else if (we_i) begin
      if (idx_i == RIDX_LOCK && wdata_i[0]) lock_o <= 1'b1;
      if (idx_i == RIDX_CTRL) begin
        if (!lock_o) en_o <= wdata_i[0];
        clr_o <= wdata_i[1];
      end
    end
  end
endmodule

// File: rtl/avm_capture.sv
module avm_capture
  import avm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       deny_i,
  input  logic       en_i,
  input  logic       clr_i,
  input  fault_rec_t rec_i,
  output logic       pend_o,
  output fault_rec_t rec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      rec_o  <= '0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
      rec_o  <= '0;
    end else if (deny_i && en_i && !pend_o) begin
      pend_o <= 1'b1;
      rec_o  <= rec_i;
    end
  end
endmodule

// File: rtl/acc_viol_mon.sv
module acc_viol_mon
  import avm_pkg::*;
#(
  parameter int unsigned   AW          = 32,
  parameter int unsigned   SHIFT       = 2,
  parameter logic [AW-1:0] REGION_BASE = 32'h4000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               deny_i,
  input  logic [AW-1:0]      acc_addr_i,
  input  logic               acc_wr_i,
  input  logic               acc_ls_i,
  input  logic [WORLD_W-1:0] acc_world_i,
  input  logic [BE_W-1:0]    acc_be_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_idx_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned STA_W = 2 + WORLD_W + BE_W + FIELD_W;

  logic       lock_w, en_w, clr_w, pend_w;
  fault_rec_t rec_in, rec_w;
  logic [FIELD_W-1:0] field_w;
  reg_idx_e   idx_w;

  assign idx_w = reg_idx_e'(reg_idx_i);

  avm_addr_pack #(.AW(AW), .SHIFT(SHIFT), .REGION_BASE(REGION_BASE)) u_pack (
    .addr_i (acc_addr_i),
    .field_o(field_w)
  );

  always_comb begin
    rec_in.wr    = acc_wr_i;
    rec_in.ls    = acc_ls_i;
    rec_in.world = acc_world_i;
    rec_in.be    = acc_be_i;
    rec_in.field = field_w;
  end

  avm_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .idx_i  (idx_w),
    .wdata_i(reg_wdata_i),
    .lock_o (lock_w),
    .en_o   (en_w),
    .clr_o  (clr_w)
  );

  avm_capture u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .deny_i(deny_i),
    .en_i  (en_w),
    .clr_i (clr_w),
    .rec_i (rec_in),
    .pend_o(pend_w),
    .rec_o (rec_w)
  );

  assign irq_o = pend_w;

  always_comb begin
    unique case (idx_w)
      RIDX_LOCK: reg_rdata_o = {31'd0, lock_w};
      RIDX_CTRL: reg_rdata_o = {30'd0, clr_w, en_w};
      RIDX_STA:  reg_rdata_o = 32'({rec_w.field, rec_w.be, rec_w.world, rec_w.ls, pend_w});
      default:   reg_rdata_o = {31'd0, rec_w.wr};
    endcase
  end

  initial begin
    if (STA_W > 32) $error("status A does not fit in 32 bits");
  end
endmodule

// File: rtl/avm_checker.sv
module avm_checker
  import avm_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       deny_i,
  input logic       irq_o,
  input logic       lock_q,
  input logic       en_q,
  input logic       clr_q,
  input fault_rec_t rec_q
);
  a_r2_rise_from_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(deny_i && en_q && !clr_q));

  a_r3_no_capture_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !irq_o) |=> !irq_o);

  a_r4_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_q) |=> (irq_o && $stable(rec_q)));

  a_r5_clear_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> (!irq_o && rec_q == '0));

  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  a_r8_enable_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(en_q));
endmodule

bind acc_viol_mon avm_checker u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .deny_i(deny_i),
  .irq_o (irq_o),
  .lock_q(lock_w),
  .en_q  (en_w),
  .clr_q (clr_w),
  .rec_q (rec_w)
);

// File: tb/sim_acc_viol_mon.sv
`timescale 1ns/1ps
module sim_acc_viol_mon;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        deny_i = 1'b0, acc_wr_i = 1'b0, acc_ls_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_world_i = '0;
  logic [3:0]  acc_be_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  acc_viol_mon u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    reg_idx_i = idx;
    #1 d = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic deny(input logic [31:0] a, input logic w, input logic ls,
                      input logic [1:0] wo, input logic [3:0] be);
    @(negedge clk_i);
    deny_i = 1'b1; acc_addr_i = a; acc_wr_i = w; acc_ls_i = ls;
    acc_world_i = wo; acc_be_i = be;
    @(negedge clk_i);
    deny_i = 1'b0;
  endtask

  function automatic logic [31:0] sta(input logic [31:0] a, input logic ls,
                                      input logic [1:0] wo, input logic [3:0] be);
    logic [19:0] f = 20'(((a - BASE) >> 2) + 1);
    return {4'd0, f, be, wo, ls, 1'b1};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      chk("R1 reg", d, 32'd0);
    end
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    deny(BASE + 32'h40, 1'b1, 1'b1, 2'd1, 4'hF);
    chk("R3 irq", {31'd0, irq_o}, 32'd0);
    rd(2'd2, d); chk("R3 status", d, 32'd0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    wr(2'd1, 32'd1);
    deny(BASE + 32'h10, 1'b1, 1'b1, 2'd2, 4'hF);
    chk("R2 irq", {31'd0, irq_o}, 32'd1);
    rd(2'd2, d); chk("R2 R6 status A", d, sta(BASE + 32'h10, 1'b1, 2'd2, 4'hF));
    chk("R6 field 5", {12'd0, d[27:8]}, 32'd5);
    rd(2'd3, d); chk("R2 status B write", d, 32'd1);
  endtask

  task automatic t_first_kept;
    logic [31:0] d;
    deny(BASE + 32'h800, 1'b0, 1'b0, 2'd3, 4'h1);
    chk("R4 irq", {31'd0, irq_o}, 32'd1);
    rd(2'd2, d); chk("R4 status A", d, sta(BASE + 32'h10, 1'b1, 2'd2, 4'hF));
    rd(2'd3, d); chk("R4 status B", d, 32'd1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(2'd1, 32'd3);
    @(negedge clk_i);
    chk("R5 irq cleared", {31'd0, irq_o}, 32'd0);
    rd(2'd2, d); chk("R5 status A cleared", d, 32'd0);
    rd(2'd3, d); chk("R5 status B cleared", d, 32'd0);
    deny(BASE + 32'h20, 1'b1, 1'b1, 2'd1, 4'h2);
    chk("R5 suppressed", {31'd0, irq_o}, 32'd0);
    wr(2'd1, 32'd1);
    chk("R5 still idle", {31'd0, irq_o}, 32'd0);
    deny(BASE, 1'b0, 1'b0, 2'd1, 4'h3);
    chk("R5 recapture", {31'd0, irq_o}, 32'd1);
    rd(2'd2, d); chk("R6 base field", d, sta(BASE, 1'b0, 2'd1, 4'h3));
    chk("R6 field 1", {12'd0, d[27:8]}, 32'd1);
    rd(2'd3, d); chk("R2 read flag", d, 32'd0);
  endtask

  task automatic t_ro;
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R9 status A", d, sta(BASE, 1'b0, 2'd1, 4'h3));
    rd(2'd3, d); chk("R9 status B", d, 32'd0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(2'd1, 32'd3);
    wr(2'd1, 32'd1);
    chk("R5 cleared before lock", {31'd0, irq_o}, 32'd0);
    wr(2'd0, 32'd0);
    rd(2'd0, d); chk("R7 zero write no lock", d, 32'd0);
    wr(2'd0, 32'd1);
    rd(2'd0, d); chk("R7 lock reads 1", d, 32'd1);
    wr(2'd0, 32'd0);
    rd(2'd0, d); chk("R7 lock sticky", d, 32'd1);
    wr(2'd1, 32'd0);
    rd(2'd1, d); chk("R8 enable kept", d, 32'd1);
    deny(BASE + 32'h100, 1'b1, 1'b0, 2'd0, 4'h8);
    chk("R8 still monitoring", {31'd0, irq_o}, 32'd1);
    wr(2'd1, 32'd2);
    rd(2'd1, d); chk("R8 clear taken, enable kept", d, 32'd3);
    @(negedge clk_i);
    chk("R8 clear works when locked", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_disabled();
    t_capture();
    t_first_kept();
    t_clear();
    t_ro();
    t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule